// File: doc/BRIEF.md
# Forward Branch Target Tracker

This block sits beside the fetch stage of a bytecode processor and turns forward branch resolution into a single compare per cycle. A loader fills a small table of pairs. Each pair holds the address where a forward jump starts (the origin) and the address it lands on (the landing). The pairs are kept in strictly ascending order of origin. The tracker holds a cursor on the next pair whose origin the program counter has not yet gone past. In every cycle it compares the program counter with that one origin, and on a match it presents the landing address in the same cycle.

If the program counter drops to a lower address, as on a loop back-edge or a call, the cursor no longer holds. The tracker then walks the table from the first pair, one pair per clock, and keeps `ready` low so the processor stalls until the walk ends. If the program counter skips over the pair under the cursor, the walk starts from the cursor instead of from the first pair. An if/else construct takes two pairs: the if jumps to just past the else, and the else jumps to just past the end.

Top module: `fwd_branch_tracker`

## Requirements
- R1: While reset is applied with `tbl_len` = 0, `ready` is 1 and `hit` is 0. Reset leaves the cursor on pair 0 in tracking mode.
- R2: In tracking mode, if the cursor is below `tbl_len` and `pc` equals the origin of the pair under the cursor, `hit` is 1 and `hit_dst` is that pair's landing address in the same cycle. The cursor then advances by one at the next clock edge.
- R3: When `pc` steps up by one each cycle, `ready` stays 1 and `hit` is 1 at exactly the cycles where `pc` equals a loaded origin, taking the pairs in index order. This covers the two consecutive pairs of an if/else.
- R4: If `pc` is lower than its value in the previous cycle, `ready` is 0 in that cycle. The cursor restarts at pair 0 and advances one pair per cycle. It stops at the first pair whose origin is greater than or equal to `pc`, or at `tbl_len`. With `pc` held, `ready` stays 0 for k+2 cycles in total, where k is the number of loaded origins below `pc`.
- R5: If `pc` rises above the origin under the cursor without a backward move, the walk continues from the cursor rather than from pair 0. Starting from the cursor at pair 0, `ready` stays 0 for k+1 cycles, where k ≥ 1 is the number of origins below `pc`. With k = 0 there is no stall.
- R6: Once the cursor reaches `tbl_len`, `hit` stays 0 and `ready` stays 1 for any `pc` that does not move backward.
- R7: `hit` is never 1 while `ready` is 0.
- R8: After a cycle with `wr_en` = 1, the next cycle has `ready` = 0, and the walk restarts at pair 0.
- R9: Pairs at an index of `tbl_len` or above never produce a hit, even if they hold data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Writes one table pair |
| wr_idx | input | IDX_W | Index of the pair being written |
| wr_src | input | ADDR_W | Origin address to write |
| wr_dst | input | ADDR_W | Landing address to write |
| tbl_len | input | CNT_W | Number of valid pairs, counted from index 0 |
| pc | input | ADDR_W | Current program counter |
| ready | output | 1 | Cursor is valid; low while the table is being walked |
| hit | output | 1 | `pc` matches the origin under the cursor |
| hit_dst | output | ADDR_W | Landing address of the matched pair |

## Verification
The bench loads eight ascending origins and sweeps `pc` upward one step at a time. This tells a correct compare-and-advance apart from a cursor that skips or repeats pairs. It then jumps backward from the top of the address range to every lower address and counts the stall cycles. This separates a restart at pair 0 from a walk that continues from the cursor, and it exposes off-by-one termination at equal origins. Forward jumps from address 0 to every higher address check the stall length of the forward walk. A sweep with the table shortened and then rewritten shows that pairs beyond the length stay silent and that a write forces a fresh walk.

// File: rtl/fbt_pkg.sv
package fbt_pkg;
  typedef enum logic {
    MODE_TRACK = 1'b0,
    MODE_SCAN  = 1'b1
  } fbt_mode_e;
endpackage

// File: rtl/fbt_rst_sync.sv
module fbt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/fbt_table.sv
module fbt_table #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_src,
  input  logic [ADDR_W-1:0] wr_dst,
  input  logic [CNT_W-1:0]  rd_ptr,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst
);
  logic [ADDR_W-1:0] src_mem [DEPTH];
  logic [ADDR_W-1:0] dst_mem [DEPTH];

  // One storage slot per pair, each with its own clock enable.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        src_mem[g] <= wr_src;
        dst_mem[g] <= wr_dst;
      end
    end
  end

  // Read mux; cursor values at or past DEPTH read as zero.
  always_comb begin
    rd_src = '0;
    rd_dst = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_ptr == CNT_W'(i)) begin
        rd_src = src_mem[i];
        rd_dst = dst_mem[i];
      end
    end
  end
endmodule

// File: rtl/fbt_cmp.sv
module fbt_cmp #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc,
  input  logic [CNT_W-1:0]  ptr,
  input  logic [CNT_W-1:0]  tbl_len,
  input  logic [ADDR_W-1:0] ent_src,
  output logic              back,
  output logic              ent_valid,
  output logic              ent_lt,
  output logic              ent_eq
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] pc_prev_q;
  logic              pc_prev_en;

  assign pc_prev_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_prev_q <= '0;
    end else if (pc_prev_en) begin
      pc_prev_q <= pc;
    end
  end

  assign back      = (pc < pc_prev_q);
  assign ent_valid = (ptr < tbl_len) && (ptr < DEPTH_C);
  assign ent_lt    = (ent_src < pc);
  assign ent_eq    = (ent_src == pc);
endmodule

// File: rtl/fbt_ctrl.sv
module fbt_ctrl
  import fbt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             back,
  input  logic             ent_valid,
  input  logic             ent_lt,
  input  logic             ent_eq,
  output logic [CNT_W-1:0] ptr_q,
  output logic             ready,
  output logic             hit
);
  fbt_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] ptr_d;
  logic             ptr_en;
  logic             mode_en;
  logic             stale;

  assign stale = ent_valid && ent_lt;

  always_comb begin
    mode_d = mode_q;
    ptr_d  = ptr_q;
    ready  = 1'b0;
    hit    = 1'b0;
    unique case (mode_q)
      MODE_TRACK: begin
        if (back) begin
          ptr_d  = '0;
          mode_d = MODE_SCAN;
        end else if (stale) begin
          ptr_d  = ptr_q + CNT_W'(1);
          mode_d = MODE_SCAN;
        end else begin
          ready = 1'b1;
          if (ent_valid && ent_eq) begin
            hit   = 1'b1;
            ptr_d = ptr_q + CNT_W'(1);
          end
        end
      end
      MODE_SCAN: begin
        if (back) begin
          ptr_d = '0;
        end else if (stale) begin
          ptr_d = ptr_q + CNT_W'(1);
        end else begin
          mode_d = MODE_TRACK;
        end
      end
      default: begin
        mode_d = MODE_SCAN;
        ptr_d  = '0;
      end
    endcase
    if (wr_en) begin
      ptr_d  = '0;
      mode_d = MODE_SCAN;
    end
  end

  assign ptr_en  = (ptr_d != ptr_q);
  assign mode_en = (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_TRACK;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/fwd_branch_tracker.sv
module fwd_branch_tracker #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_src,
  input  logic [ADDR_W-1:0] wr_dst,
  input  logic [CNT_W-1:0]  tbl_len,
  input  logic [ADDR_W-1:0] pc,
  output logic              ready,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_dst
);
  logic              rst_sync_n;
  logic [CNT_W-1:0]  ptr_q;
  logic [ADDR_W-1:0] ent_src;
  logic [ADDR_W-1:0] ent_dst;
  logic              back;
  logic              ent_valid;
  logic              ent_lt;
  logic              ent_eq;

  fbt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fbt_table #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
  ) u_table (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_src (wr_src),
    .wr_dst (wr_dst),
    .rd_ptr (ptr_q),
    .rd_src (ent_src),
    .rd_dst (ent_dst)
  );

  fbt_cmp #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
  ) u_cmp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pc        (pc),
    .ptr       (ptr_q),
    .tbl_len   (tbl_len),
    .ent_src   (ent_src),
    .back      (back),
    .ent_valid (ent_valid),
    .ent_lt    (ent_lt),
    .ent_eq    (ent_eq)
  );

  fbt_ctrl #(
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .back      (back),
    .ent_valid (ent_valid),
    .ent_lt    (ent_lt),
    .ent_eq    (ent_eq),
    .ptr_q     (ptr_q),
    .ready     (ready),
    .hit       (hit)
  );

  assign hit_dst = hit ? ent_dst : '0;
endmodule

// File: rtl/fbt_chk.sv
module fbt_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CNT_W-1:0]  tbl_len,
  input logic [ADDR_W-1:0] pc,
  input logic [CNT_W-1:0]  ptr_q,
  input logic              ready,
  input logic              hit
);
  logic [ADDR_W-1:0] pc_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_seen_q <= '0;
    else        pc_seen_q <= pc;
  end

  // R7
  hit_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ready);

  // R4
  back_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc < pc_seen_q) |-> !ready);

  // R6
  end_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q >= tbl_len) |-> !hit);

  // R2
  hit_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !wr_en) |=> (ptr_q == $past(ptr_q) + CNT_W'(1)));

  // R8
  write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr_q == '0) && !ready);
endmodule

bind fwd_branch_tracker fbt_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .tbl_len (tbl_len),
  .pc      (pc),
  .ptr_q   (ptr_q),
  .ready   (ready),
  .hit     (hit)
);

// File: tb/fwd_branch_tracker_tb.sv
module fwd_branch_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 8;
  localparam int IDX_W  = 3;
  localparam int CNT_W  = 4;
  localparam int TOP_PC = 55;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] wr_src;
  logic [ADDR_W-1:0] wr_dst;
  logic [CNT_W-1:0]  tbl_len;
  logic [ADDR_W-1:0] pc;
  logic              ready;
  logic              hit;
  logic [ADDR_W-1:0] hit_dst;

  int n_checks;
  int n_fail;

  fwd_branch_tracker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_src(wr_src), .wr_dst(wr_dst), .tbl_len(tbl_len), .pc(pc),
    .ready(ready), .hit(hit), .hit_dst(hit_dst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int org(input int i);
    return 2 + 3*i + (i*i)/2;
  endfunction

  function automatic int land(input int i);
    return org(i) + 7 + i;
  endfunction

  function automatic int below(input int t, input int len);
    int k = 0;
    for (int i = 0; i < len; i++) if (org(i) < t) k++;
    return k;
  endfunction

  function automatic int match_idx(input int t, input int len);
    for (int i = 0; i < len; i++) if (org(i) == t) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int v, output int n, output int h, output int d);
    @(negedge clk);
    pc = ADDR_W'(v);
    #2;
    n = 0;
    while (ready !== 1'b1 && n < 200) begin
      if (hit === 1'b1) check(1'b0, "R7 hit while not ready", 1, 0);
      n++;
      @(negedge clk);
      #2;
    end
    h = int'(hit);
    d = int'(hit_dst);
  endtask

  task automatic write_pair(input int i, input int s, input int d);
    @(negedge clk);
    wr_en  = 1'b1;
    wr_idx = IDX_W'(i);
    wr_src = ADDR_W'(s);
    wr_dst = ADDR_W'(d);
    @(negedge clk);
    wr_en  = 1'b0;
  endtask

  task automatic step_sweep(input int len, input string req);
    int n, h, d, m;
    for (int p = 0; p <= TOP_PC; p++) begin
      settle(p, n, h, d);
      m = match_idx(p, len);
      check(n == 0, {req, " ready during upward step"}, n, 0);
      check(h == (m >= 0 ? 1 : 0), {req, " hit at step"}, h, (m >= 0 ? 1 : 0));
      if (m >= 0) check(d == land(m), {req, " landing address"}, d, land(m));
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n, h, d, k, m;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_src = '0; wr_dst = '0;
    tbl_len = '0; pc = '0;
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state
    check(ready === 1'b1, "R1 ready in reset", int'(ready), 1);
    check(hit === 1'b0, "R1 hit in reset", int'(hit), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < DEPTH; i++) write_pair(i, org(i), land(i));
    tbl_len = CNT_W'(DEPTH);
    settle(0, n, h, d);

    // R2 R3: upward stepping over the full table (if/else pairs included)
    step_sweep(DEPTH, "R3");

    // R4: backward jumps from the top to every lower address
    for (int t = 0; t < TOP_PC; t++) begin
      settle(TOP_PC, n, h, d);
      settle(t, n, h, d);
      k = below(t, DEPTH);
      m = match_idx(t, DEPTH);
      check(n == k + 2, "R4 backward stall length", n, k + 2);
      check(h == (m >= 0 ? 1 : 0), "R4 hit after walk", h, (m >= 0 ? 1 : 0));
      if (m >= 0) check(d == land(m), "R2 landing after walk", d, land(m));
    end

    // R5: forward jumps from address 0
    for (int t = 1; t <= TOP_PC; t++) begin
      settle(0, n, h, d);
      settle(t, n, h, d);
      k = below(t, DEPTH);
      m = match_idx(t, DEPTH);
      check(n == (k == 0 ? 0 : k + 1), "R5 forward stall length", n, (k == 0 ? 0 : k + 1));
      check(h == (m >= 0 ? 1 : 0), "R5 hit after forward walk", h, (m >= 0 ? 1 : 0));
    end

    // R6: cursor at end of table, pc keeps rising
    settle(org(DEPTH-1), n, h, d);
    for (int p = org(DEPTH-1) + 1; p <= org(DEPTH-1) + 6; p++) begin
      settle(p, n, h, d);
      check(n == 0 && h == 0, "R6 silent past last pair", h + n, 0);
    end

    // R8: a write restarts the walk
    settle(0, n, h, d);
    tbl_len = CNT_W'(4);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = '0; wr_src = ADDR_W'(org(0)); wr_dst = ADDR_W'(land(0));
    @(negedge clk);
    wr_en = 1'b0;
    #2;
    check(ready === 1'b0, "R8 not ready after write", int'(ready), 0);
    @(negedge clk);
    #2;
    check(ready === 1'b1, "R8 ready after short walk", int'(ready), 1);

    // R9: shortened table, pairs beyond the length stay silent
    step_sweep(4, "R9");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule